// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block owns the per-port command-issue vector of a host storage controller and decides which slot is handed to the port's single command engine. Software posts work by writing issue bits, and a write only adds bits to what is already posted. A separate control write sets the start and frame-receive enables. The running flags follow those enables.

While start is set and any issue bit is posted, the scheduler offers the lowest-numbered posted slot to the engine. It does so only when the engine reports neither busy nor data-request. On the cycle after the offer it samples the engine again. If the engine is already idle, the command is treated as finished and the slot's bit is retired. If the engine is still working, the slot is held as the pending slot until busy and data-request both drop. Only then is its bit retired and scanning resumed. Command fetch, decode and the engine itself are outside this block. They appear only as the dispatch strobe and the two engine status inputs.

Top module: `cmd_slot_sched`

## Requirements
- R1: A write strobe on the issue port ORs the written vector into the issue register (bit n is slot n). Bits that are already set remain set. The result is visible on `issue_q` one cycle later.
- R2: A control write loads `start_en` and `fisrx_en` from the written values. In the same edge it loads `list_run` equal to the written start value and `fis_run` equal to the written frame-receive value. Without a control write, all four flags hold.
- R3: `disp_valid` is high in a cycle only when all of these hold: the scheduler is scanning, `start_en` is 1, the issue register is nonzero, and `eng_bsy` and `eng_drq` are both 0. `disp_slot` then gives the binary index of the lowest-numbered set issue bit.
- R4: In the cycle after a dispatch, if `eng_bsy` and `eng_drq` are both 0, the dispatched slot's issue bit is cleared at that cycle's closing edge, and scanning resumes.
- R5: In the cycle after a dispatch, if the engine reports busy or data-request, the slot becomes pending. From the next cycle, `pend_valid` is 1 and `pend_slot` shows the slot index; `pend_slot` is 0 whenever `pend_valid` is 0. The slot's issue bit stays set. At the first edge where busy and data-request are both 0, the bit is cleared and `pend_valid` falls.
- R6: At most one slot is dispatched per engine handshake. There is no dispatch in the check cycle after a dispatch, and none while a slot is pending.
- R7: With `start_en` at 0 nothing is dispatched and posted issue bits are kept. A pending slot still retires when the engine goes idle.
- R8: If a slot's issue bit is written in the same edge in which that slot retires, the bit stays set.
- R9: After reset the issue register, all four flags, `disp_valid` and `pend_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_wr | input | 1 | Issue register write strobe |
| issue_wdata | input | NUM_SLOTS | Bits to OR into the issue register |
| ctl_wr | input | 1 | Port control write strobe |
| ctl_start | input | 1 | Written start enable |
| ctl_fisrx | input | 1 | Written frame-receive enable |
| eng_bsy | input | 1 | Engine busy |
| eng_drq | input | 1 | Engine data request |
| start_en | output | 1 | Start enable |
| fisrx_en | output | 1 | Frame-receive enable |
| list_run | output | 1 | Command list running flag |
| fis_run | output | 1 | Frame receive running flag |
| issue_q | output | NUM_SLOTS | Issue register |
| disp_valid | output | 1 | Dispatch strobe to the engine |
| disp_slot | output | SLOT_W | Dispatched slot index |
| pend_valid | output | 1 | A dispatched slot is still in progress |
| pend_slot | output | SLOT_W | Index of the in-progress slot |

## Verification
The assertions assume that `eng_bsy` and `eng_drq` describe the engine as sampled in the current cycle, and that the engine goes busy, if at all, in the cycle right after a dispatch. They also assume that the status lines are synchronous, so that a strobe write and an engine drop may coincide. The stimulus drives every input away from the clock edge, on the falling edge. It raises busy or data-request only in the cycle after a dispatch or while a slot is pending. The one exception is the engine-blocked case, where the strobes are held high before any dispatch. In the collision case the stimulus writes the same bit in exactly the edge in which that slot retires.

// File: rtl/cmd_sched_pkg.sv
package cmd_sched_pkg;
  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_CHECK = 2'd1,
    ST_HOLD  = 2'd2
  } sched_st_e;

  // engine is free to take or to retire a command
  function automatic logic engine_free(input logic bsy, input logic drq);
    return !(bsy || drq);
  endfunction
endpackage

// File: rtl/slot_picker.sv
module slot_picker #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] vec,
  output logic                 any,
  output logic [SLOT_W-1:0]    idx
);
  // scan from the top so the lowest set bit is the last to write idx
  always_comb begin
    idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (vec[i]) idx = SLOT_W'(i);
    end
  end

  assign any = |vec;
endmodule

// File: rtl/issue_reg.sv
module issue_reg #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [NUM_SLOTS-1:0] set_val,
  input  logic                 clr_en,
  input  logic [SLOT_W-1:0]    clr_idx,
  output logic [NUM_SLOTS-1:0] q
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
    logic set_b, clr_b;
    assign set_b = set_en && set_val[g];
    assign clr_b = clr_en && (clr_idx == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= 1'b0;
      else if (set_b) q[g] <= 1'b1;   // a new post wins over retirement
      else if (clr_b) q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/port_flags.sv
module port_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic start_in,
  input  logic fisrx_in,
  output logic start_en,
  output logic fisrx_en,
  output logic list_run,
  output logic fis_run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_en <= 1'b0;
      fisrx_en <= 1'b0;
      list_run <= 1'b0;
      fis_run  <= 1'b0;
    end else if (wr) begin
      start_en <= start_in;
      fisrx_en <= fisrx_in;
      list_run <= start_in;
      fis_run  <= fisrx_in;
    end
  end
endmodule

// File: rtl/dispatch_fsm.sv
module dispatch_fsm
  import cmd_sched_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_en,
  input  logic              any_issued,
  input  logic [SLOT_W-1:0] pick_idx,
  input  logic              eng_bsy,
  input  logic              eng_drq,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_slot,
  output logic              clr_en,
  output logic [SLOT_W-1:0] clr_idx,
  output logic              pend_valid,
  output logic [SLOT_W-1:0] pend_slot
);
  sched_st_e         st, st_n;
  logic [SLOT_W-1:0] cur_slot;
  logic              free;

  assign free       = engine_free(eng_bsy, eng_drq);
  assign disp_valid = (st == ST_SCAN) && start_en && any_issued && free;
  assign disp_slot  = pick_idx;
  assign clr_en     = ((st == ST_CHECK) || (st == ST_HOLD)) && free;
  assign clr_idx    = cur_slot;
  assign pend_valid = (st == ST_HOLD);
  assign pend_slot  = pend_valid ? cur_slot : '0;

  always_comb begin
    st_n = st;
    unique case (st)
      ST_SCAN:  if (disp_valid) st_n = ST_CHECK;
      ST_CHECK: st_n = free ? ST_SCAN : ST_HOLD;
      ST_HOLD:  if (free) st_n = ST_SCAN;
      default:  st_n = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_SCAN;
      cur_slot <= '0;
    end else begin
      st <= st_n;
      if (disp_valid) cur_slot <= pick_idx;
    end
  end

  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid); // R6
  AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !eng_bsy && !eng_drq) |=> !pend_valid); // R5
endmodule

// File: rtl/cmd_slot_sched.sv
module cmd_slot_sched #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_wr,
  input  logic [NUM_SLOTS-1:0] issue_wdata,
  input  logic                 ctl_wr,
  input  logic                 ctl_start,
  input  logic                 ctl_fisrx,
  input  logic                 eng_bsy,
  input  logic                 eng_drq,
  output logic                 start_en,
  output logic                 fisrx_en,
  output logic                 list_run,
  output logic                 fis_run,
  output logic [NUM_SLOTS-1:0] issue_q,
  output logic                 disp_valid,
  output logic [SLOT_W-1:0]    disp_slot,
  output logic                 pend_valid,
  output logic [SLOT_W-1:0]    pend_slot
);
  logic              any_issued;
  logic [SLOT_W-1:0] pick_idx;
  logic              clr_en;
  logic [SLOT_W-1:0] clr_idx;

  port_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr),
    .start_in(ctl_start), .fisrx_in(ctl_fisrx),
    .start_en(start_en), .fisrx_en(fisrx_en),
    .list_run(list_run), .fis_run(fis_run)
  );

  issue_reg #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue_wr), .set_val(issue_wdata),
    .clr_en(clr_en), .clr_idx(clr_idx), .q(issue_q)
  );

  slot_picker #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .vec(issue_q), .any(any_issued), .idx(pick_idx)
  );

  dispatch_fsm #(.SLOT_W(SLOT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_en(start_en),
    .any_issued(any_issued), .pick_idx(pick_idx),
    .eng_bsy(eng_bsy), .eng_drq(eng_drq),
    .disp_valid(disp_valid), .disp_slot(disp_slot),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .pend_valid(pend_valid), .pend_slot(pend_slot)
  );

  AST_OR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    issue_wr |=> ((issue_q & $past(issue_wdata)) == $past(issue_wdata))); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({start_en, fisrx_en, list_run, fis_run})); // R2
  AST_DISP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (start_en && !eng_bsy && !eng_drq && issue_q[disp_slot])); // R3
  AST_PEND_KEEPS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> issue_q[pend_slot]); // R5
  AST_NO_DISP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> !disp_valid); // R6
endmodule

// File: tb/cmd_slot_sched_bench.sv
module cmd_slot_sched_bench;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_wr = 1'b0;
  logic [N-1:0]  issue_wdata = '0;
  logic          ctl_wr = 1'b0, ctl_start = 1'b0, ctl_fisrx = 1'b0;
  logic          eng_bsy = 1'b0, eng_drq = 1'b0;
  logic          start_en, fisrx_en, list_run, fis_run;
  logic [N-1:0]  issue_q;
  logic          disp_valid, pend_valid;
  logic [4:0]    disp_slot, pend_slot;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R9";

  // reference state
  logic [N-1:0] m_issue = '0;
  bit m_start = 0, m_fis = 0, m_lr = 0, m_fr = 0;
  int m_phase = 0;   // 0 scanning, 1 checking, 2 outstanding
  int m_slot = 0;

  always #2 clk = ~clk;

  cmd_slot_sched u_cmd_slot_sched (
    .clk(clk), .rst_n(rst_n), .issue_wr(issue_wr), .issue_wdata(issue_wdata),
    .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_fisrx(ctl_fisrx),
    .eng_bsy(eng_bsy), .eng_drq(eng_drq),
    .start_en(start_en), .fisrx_en(fisrx_en), .list_run(list_run), .fis_run(fis_run),
    .issue_q(issue_q), .disp_valid(disp_valid), .disp_slot(disp_slot),
    .pend_valid(pend_valid), .pend_slot(pend_slot)
  );

  task automatic chk(string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven; compare, then advance model
  task automatic cyc(bit wr, logic [N-1:0] wd, bit cw, bit cs, bit cf, bit bsy, bit drq);
    bit idle, e_disp;
    int e_slot, retire;
    issue_wr = wr; issue_wdata = wd; ctl_wr = cw; ctl_start = cs; ctl_fisrx = cf;
    eng_bsy = bsy; eng_drq = drq;
    #1;
    idle = !bsy && !drq;
    e_slot = 0;
    begin
      int k = 0;
      while (k < N && !m_issue[k]) k++;
      if (k < N) e_slot = k;
    end
    e_disp = (m_phase == 0) && m_start && (m_issue != 0) && idle;
    chk("issue_q", issue_q, m_issue);
    chk("start_en", start_en, m_start);
    chk("fisrx_en", fisrx_en, m_fis);
    chk("list_run", list_run, m_lr);
    chk("fis_run", fis_run, m_fr);
    chk("disp_valid", disp_valid, e_disp);
    if (e_disp) chk("disp_slot", disp_slot, e_slot);
    chk("pend_valid", pend_valid, m_phase == 2);
    chk("pend_slot", pend_slot, (m_phase == 2) ? m_slot : 0);
    @(posedge clk);
    retire = ((m_phase == 1 || m_phase == 2) && idle) ? m_slot : -1;
    if (retire >= 0) m_issue[retire] = 1'b0;
    if (wr) m_issue = m_issue | wd;
    if (cw) begin m_start = cs; m_fis = cf; m_lr = cs; m_fr = cf; end
    if (e_disp) begin m_phase = 1; m_slot = e_slot; end
    else if (m_phase == 1) m_phase = idle ? 0 : 2;
    else if (m_phase == 2 && idle) m_phase = 0;
    @(negedge clk);
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tag = "R9";                 // reset state held while rst_n low
    cyc(0, '0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    idle_n(2);

    tag = "R1";                 // OR-in writes
    cyc(1, 32'h0000_0005, 0, 0, 0, 0, 0);
    cyc(1, 32'h0000_0010, 0, 0, 0, 0, 0);
    cyc(1, 32'h0000_0001, 0, 0, 0, 0, 0);

    tag = "R2";                 // flags follow the written enables
    cyc(0, '0, 1, 0, 1, 0, 0);
    tag = "R7";                 // start off: no dispatch, bits kept
    idle_n(3);

    tag = "R3";                 // engine busy or requesting blocks dispatch
    cyc(0, '0, 1, 1, 1, 1, 0);
    cyc(0, '0, 0, 0, 0, 1, 0);
    cyc(0, '0, 0, 0, 0, 0, 1);
    tag = "R4";                 // immediate completion retires slots 0,2,4 in order
    idle_n(7);

    tag = "R5";                 // slot 0 then slot 31: slot 0 stays busy
    cyc(1, 32'h8000_0001, 0, 0, 0, 0, 0);
    cyc(0, '0, 0, 0, 0, 0, 0);          // dispatch slot 0
    cyc(0, '0, 0, 0, 0, 1, 0);          // check: busy -> outstanding
    tag = "R6";
    cyc(0, '0, 0, 0, 0, 1, 0);
    cyc(0, '0, 0, 0, 0, 0, 1);
    tag = "R8";                 // rewrite bit 0 in the retiring edge
    cyc(1, 32'h0000_0001, 0, 0, 0, 0, 0);
    tag = "R4";
    idle_n(6);                          // slot 0 again, then slot 31

    tag = "R7";                 // clear start while a slot is outstanding
    cyc(1, 32'h0000_0006, 0, 0, 0, 0, 0);
    cyc(0, '0, 0, 0, 0, 0, 0);          // dispatch slot 1
    cyc(0, '0, 0, 0, 0, 0, 1);          // outstanding
    cyc(0, '0, 1, 0, 1, 1, 0);          // start off
    cyc(0, '0, 0, 0, 0, 0, 0);          // retires slot 1
    idle_n(3);                          // slot 2 kept, not dispatched
    tag = "R2";
    cyc(0, '0, 1, 1, 0, 0, 0);
    tag = "R3";
    idle_n(4);

    tag = "R9";                 // mid-run reset returns to the reset state
    cyc(1, 32'h0000_0100, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    #1;
    m_issue = '0; m_start = 0; m_fis = 0; m_lr = 0; m_fr = 0; m_phase = 0; m_slot = 0;
    cyc(0, '0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    idle_n(2);

    finish_run();
  end
endmodule